// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns 32-bit virtual addresses into physical addresses for 4 KB pages. The low 12 bits of an address are the byte offset within the page, and they pass through translation unchanged. The upper 20 bits are the virtual page number. That number is compared against every stored mapping in the same cycle. On a match, the stored 20-bit physical page is joined to the offset and returned.

When no stored mapping matches, the block issues a read to an external page table, indexed by the virtual page number, and waits for the reply.
- A reply marked valid is stored, and its translation is returned. The new mapping goes into an empty slot if one exists; otherwise it replaces the least recently used slot.
- A reply marked invalid is returned as a page fault, and nothing is stored.

Two maintenance inputs remove mappings:
- A flush input, used on a context switch, drops every mapping.
- An invalidate input drops every mapping that points at a given physical page, for use when that page is moved out to disk.

Lookups, results and page-table traffic use valid/ready handshakes:
- A lookup is taken only in a cycle where both `req_valid` and `req_ready` are high.
- The block handles one lookup at a time. `req_ready` stays low, and `busy` stays high, from the accepted lookup until its result has been taken.
- A result stays on `res_valid`/`res_paddr`/`res_fault`, unchanged, until `res_ready` is seen high.
- A page-table request stays on `pt_req_valid`/`pt_req_vpn`, unchanged, until `pt_req_ready` is seen high.
- A page-table reply is taken while `pt_rsp_ready` is high.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every slot is empty, `req_ready` is 1, and `busy`, `res_valid` and `pt_req_valid` are 0.
- R2: A lookup whose page number matches a valid slot raises `res_valid` in the cycle after it is accepted. It gives `res_fault`=0 and `res_paddr` = {stored page, vaddr[11:0]}, and makes no page-table request. Example: page 0x00002 mapped to 0x00008 turns address 0x00002F3A into 0x00008F3A.
- R3: A lookup that matches no slot raises `pt_req_valid` in the next cycle, with `pt_req_vpn` = vaddr[31:12]. From then until the result is taken, `busy` is 1 and `req_ready` is 0.
- R4: A page-table reply with `pt_rsp_ok`=1 returns `res_paddr` = {`pt_rsp_ppn`, offset} with `res_fault`=0 in the next cycle, and stores the mapping, so a later lookup of that page hits.
- R5: A page-table reply with `pt_rsp_ok`=0 returns `res_fault`=1 with `res_paddr`=0 in the next cycle. It stores nothing, so the same page misses again.
- R6: A new mapping goes into the lowest-numbered empty slot. When no slot is empty, it replaces the slot whose last hit or install is the oldest, so a hit protects a mapping from the next replacement.
- R7: A cycle with `flush`=1 empties every slot, including a slot being filled in that same cycle (the reply is still returned as a result). The next lookup of any page misses.
- R8: A cycle with `inval_valid`=1 empties every slot whose stored physical page equals `inval_ppn`. Slots holding other pages keep hitting.
- R9: Back-pressure holds both outputs steady. While `res_ready`=0, `res_valid`, `res_paddr` and `res_fault` do not change. While `pt_req_ready`=0, `pt_req_valid` and `pt_req_vpn` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup offered |
| req_ready | output | 1 | Lookup can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Physical address (0 on a fault) |
| res_fault | output | 1 | Page fault for this lookup |
| pt_req_valid | output | 1 | Page-table read requested |
| pt_req_ready | input | 1 | Page table takes the request |
| pt_req_vpn | output | 20 | Page number to read |
| pt_rsp_valid | input | 1 | Page-table reply present |
| pt_rsp_ready | output | 1 | Block takes the reply |
| pt_rsp_ok | input | 1 | Reply holds a valid mapping |
| pt_rsp_ppn | input | 20 | Physical page in the reply |
| flush | input | 1 | Empty all slots |
| inval_valid | input | 1 | Invalidate by physical page |
| inval_ppn | input | 20 | Physical page to invalidate |
| busy | output | 1 | A lookup is in progress |

## Verification
The bench keeps the default address widths (32-bit addresses, 12-bit offset, 20-bit pages) but builds the block with only 4 slots. With 4 slots, a short sequence of lookups fills the buffer and forces replacement. That makes it possible to order hits and installs so that the slot picked for replacement is known in advance, and to check that choice through later hits and misses. With this small size, an invalidate can also hit two slots holding the same physical page while the other slots stay in place.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Controller states: taking a lookup, sending a page-table request,
  // waiting for the reply, and holding a result for the consumer.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } xlat_state_e;
endpackage

// File: rtl/xlat_cam.sv
// Compares one key against every stored tag in parallel.
module xlat_cam #(
  parameter int N     = 64,
  parameter int TAG_W = 20,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]        key,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == key);
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_victim.sv
// Chooses the slot that a new mapping goes into:
// the lowest-numbered empty slot if there is one, otherwise the oldest slot.
module xlat_victim #(
  parameter int N     = 64,
  parameter int AGE_W = 7,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][AGE_W-1:0] age,
  output logic [IDX_W-1:0]        victim
);
  logic             has_empty;
  logic [IDX_W-1:0] empty_idx;
  logic [IDX_W-1:0] old_idx;
  logic [AGE_W-1:0] best_age;

  always_comb begin
    has_empty = 1'b0;
    empty_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_empty = 1'b1;
        empty_idx = IDX_W'(i);
      end
    end

    // Strictly-greater comparison: on equal ages the lower index wins.
    old_idx  = '0;
    best_age = age[0];
    for (int i = 1; i < N; i++) begin
      if (age[i] > best_age) begin
        best_age = age[i];
        old_idx  = IDX_W'(i);
      end
    end

    victim = has_empty ? empty_idx : old_idx;
  end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFS_W   = 12,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [PPN_W+OFS_W-1:0] res_paddr,
  output logic                   res_fault,
  output logic                   pt_req_valid,
  input  logic                   pt_req_ready,
  output logic [VA_W-OFS_W-1:0]  pt_req_vpn,
  input  logic                   pt_rsp_valid,
  output logic                   pt_rsp_ready,
  input  logic                   pt_rsp_ok,
  input  logic [PPN_W-1:0]       pt_rsp_ppn,
  input  logic                   flush,
  input  logic                   inval_valid,
  input  logic [PPN_W-1:0]       inval_ppn,
  output logic                   busy
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PA_W  = PPN_W + OFS_W;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int AGE_W = IDX_W + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  // Slot storage
  logic [ENTRIES-1:0]            ent_vld;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
  logic [ENTRIES-1:0][AGE_W-1:0] ent_age;

  // Controller state
  xlat_state_e      state;
  logic [VPN_W-1:0] cur_vpn;
  logic [OFS_W-1:0] cur_ofs;
  logic [PA_W-1:0]  res_paddr_q;
  logic             res_fault_q;

  logic             look_hit;
  logic [IDX_W-1:0] look_idx;
  logic [IDX_W-1:0] victim;
  logic             lookup_fire;
  logic             rsp_fire;
  logic             install;
  logic             touch;
  logic [IDX_W-1:0] touch_idx;
  logic [ENTRIES-1:0] inval_hit;

  xlat_cam #(.N(ENTRIES), .TAG_W(VPN_W), .IDX_W(IDX_W)) i_cam (
    .vld  (ent_vld),
    .tags (ent_vpn),
    .key  (req_vaddr[VA_W-1:OFS_W]),
    .hit  (look_hit),
    .idx  (look_idx)
  );

  xlat_victim #(.N(ENTRIES), .AGE_W(AGE_W), .IDX_W(IDX_W)) i_victim (
    .vld    (ent_vld),
    .age    (ent_age),
    .victim (victim)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_inval
    assign inval_hit[g] = inval_valid && ent_vld[g] && (ent_ppn[g] == inval_ppn);
  end

  assign req_ready    = (state == ST_IDLE);
  assign busy         = (state != ST_IDLE);
  assign pt_req_valid = (state == ST_REQ);
  assign pt_req_vpn   = cur_vpn;
  assign pt_rsp_ready = (state == ST_WAIT);
  assign res_valid    = (state == ST_RESP);
  assign res_paddr    = res_paddr_q;
  assign res_fault    = res_fault_q;

  assign lookup_fire = req_valid && req_ready;
  assign rsp_fire    = pt_rsp_valid && pt_rsp_ready;
  // A flush in the same cycle cancels the store.
  assign install     = rsp_fire && pt_rsp_ok && !flush;
  assign touch       = (lookup_fire && look_hit) || install;
  assign touch_idx   = install ? victim : look_idx;

  // Slot update. Priority: flush, then install, then invalidate.
  // A slot that is touched resets its age; every other valid slot ages by one,
  // stopping at the maximum.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      ent_vpn <= '0;
      ent_ppn <= '0;
      ent_age <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush) begin
          ent_vld[i] <= 1'b0;
        end else if (install && (victim == IDX_W'(i))) begin
          ent_vld[i] <= 1'b1;
          ent_vpn[i] <= cur_vpn;
          ent_ppn[i] <= pt_rsp_ppn;
        end else if (inval_hit[i]) begin
          ent_vld[i] <= 1'b0;
        end

        if (touch) begin
          if (touch_idx == IDX_W'(i)) begin
            ent_age[i] <= '0;
          end else if (ent_vld[i] && (ent_age[i] != AGE_MAX)) begin
            ent_age[i] <= ent_age[i] + 1'b1;
          end
        end
      end
    end
  end

  // Lookup sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_vpn     <= '0;
      cur_ofs     <= '0;
      res_paddr_q <= '0;
      res_fault_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (lookup_fire) begin
            cur_vpn <= req_vaddr[VA_W-1:OFS_W];
            cur_ofs <= req_vaddr[OFS_W-1:0];
            if (look_hit) begin
              res_paddr_q <= {ent_ppn[look_idx], req_vaddr[OFS_W-1:0]};
              res_fault_q <= 1'b0;
              state       <= ST_RESP;
            end else begin
              state <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (pt_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_fire) begin
            res_paddr_q <= pt_rsp_ok ? {pt_rsp_ppn, cur_ofs} : '0;
            res_fault_q <= !pt_rsp_ok;
            state       <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
  parameter int VA_W  = 32,
  parameter int OFS_W = 12,
  parameter int PPN_W = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [VA_W-1:0]        req_vaddr,
  input logic                   res_valid,
  input logic                   res_ready,
  input logic [PPN_W+OFS_W-1:0] res_paddr,
  input logic                   res_fault,
  input logic                   pt_req_valid,
  input logic                   pt_req_ready,
  input logic [VA_W-OFS_W-1:0]  pt_req_vpn,
  input logic                   pt_rsp_valid,
  input logic                   pt_rsp_ready,
  input logic                   pt_rsp_ok,
  input logic [PPN_W-1:0]       pt_rsp_ppn,
  input logic                   flush,
  input logic                   busy
);
  localparam int PA_W = PPN_W + OFS_W;

  // Records of the most recently accepted lookup, and a one-cycle copy of flush.
  logic [OFS_W-1:0]      seen_ofs;
  logic [VA_W-OFS_W-1:0] seen_vpn;
  logic                  flush_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_ofs <= '0;
      seen_vpn <= '0;
      flush_d  <= 1'b0;
    end else begin
      flush_d <= flush;
      if (req_valid && req_ready) begin
        seen_ofs <= req_vaddr[OFS_W-1:0];
        seen_vpn <= req_vaddr[VA_W-1:OFS_W];
      end
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_ready && !busy && !res_valid && !pt_req_valid));

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |-> (res_paddr[OFS_W-1:0] == seen_ofs));

  p_walk_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req_valid |-> (pt_req_vpn == seen_vpn && busy && !req_ready));

  p_install_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_rsp_valid && pt_rsp_ready && pt_rsp_ok) |=>
      (res_valid && !res_fault && res_paddr[PA_W-1:OFS_W] == $past(pt_rsp_ppn)));

  p_fault_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_rsp_valid && pt_rsp_ready && !pt_rsp_ok) |=>
      (res_valid && res_fault && res_paddr == '0));

  p_flush_misses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_d && req_valid && req_ready) |=> pt_req_valid);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_paddr) && $stable(res_fault)));

  p_walk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_req_valid && !pt_req_ready) |=> (pt_req_valid && $stable(pt_req_vpn)));
endmodule

bind xlat_buffer xlat_buffer_chk #(.VA_W(VA_W), .OFS_W(OFS_W), .PPN_W(PPN_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_vaddr    (req_vaddr),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_paddr    (res_paddr),
  .res_fault    (res_fault),
  .pt_req_valid (pt_req_valid),
  .pt_req_ready (pt_req_ready),
  .pt_req_vpn   (pt_req_vpn),
  .pt_rsp_valid (pt_rsp_valid),
  .pt_rsp_ready (pt_rsp_ready),
  .pt_rsp_ok    (pt_rsp_ok),
  .pt_rsp_ppn   (pt_rsp_ppn),
  .flush        (flush),
  .busy         (busy)
);

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;
  localparam int VA_W    = 32;
  localparam int OFS_W   = 12;
  localparam int PPN_W   = 20;
  localparam int ENTRIES = 4;
  localparam int ROW_W   = 32 + 1 + 20 + 1 + 1 + 32;
  localparam int NVEC    = 12;

  // Row layout: {vaddr, reply ok, reply page, expect miss, expect fault, expect paddr}
  localparam logic [ROW_W-1:0] VEC [NVEC] = '{
    {32'h00002F3A, 1'b1, 20'h00008, 1'b1, 1'b0, 32'h00008F3A},  // R4 install into slot 0
    {32'h00002010, 1'b0, 20'h00000, 1'b0, 1'b0, 32'h00008010},  // R2 R4 hit
    {32'h12345000, 1'b1, 20'hABCDE, 1'b1, 1'b0, 32'hABCDE000},  // R6 empty slot 1
    {32'h00777FFF, 1'b0, 20'h00000, 1'b1, 1'b1, 32'h00000000},  // R5 fault
    {32'h00777001, 1'b1, 20'h00100, 1'b1, 1'b0, 32'h00100001},  // R5 still a miss
    {32'hFFFFF123, 1'b1, 20'h00055, 1'b1, 1'b0, 32'h00055123},  // buffer now full
    {32'h00002004, 1'b0, 20'h00000, 1'b0, 1'b0, 32'h00008004},  // R6 hit protects page 2
    {32'h00AAA000, 1'b1, 20'h00A0A, 1'b1, 1'b0, 32'h00A0A000},  // R6 replaces 0x12345
    {32'h12345456, 1'b1, 20'h0BEEF, 1'b1, 1'b0, 32'h0BEEF456},  // R6 replaces 0x00777
    {32'h00002999, 1'b0, 20'h00000, 1'b0, 1'b0, 32'h00008999},  // R6 page 2 kept
    {32'hFFFFFABC, 1'b0, 20'h00000, 1'b0, 1'b0, 32'h00055ABC},  // R2 hit
    {32'h00777000, 1'b1, 20'h00101, 1'b1, 1'b0, 32'h00101000}   // R6 replaces 0x00AAA
  };

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   req_valid = 1'b0;
  logic                   req_ready;
  logic [VA_W-1:0]        req_vaddr = '0;
  logic                   res_valid;
  logic                   res_ready = 1'b0;
  logic [PPN_W+OFS_W-1:0] res_paddr;
  logic                   res_fault;
  logic                   pt_req_valid;
  logic                   pt_req_ready = 1'b0;
  logic [VA_W-OFS_W-1:0]  pt_req_vpn;
  logic                   pt_rsp_valid = 1'b0;
  logic                   pt_rsp_ready;
  logic                   pt_rsp_ok = 1'b0;
  logic [PPN_W-1:0]       pt_rsp_ppn = '0;
  logic                   flush = 1'b0;
  logic                   inval_valid = 1'b0;
  logic [PPN_W-1:0]       inval_ppn = '0;
  logic                   busy;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  xlat_buffer #(.VA_W(VA_W), .OFS_W(OFS_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES)) i_xlat_buffer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr), .res_fault(res_fault),
    .pt_req_valid(pt_req_valid), .pt_req_ready(pt_req_ready), .pt_req_vpn(pt_req_vpn),
    .pt_rsp_valid(pt_rsp_valid), .pt_rsp_ready(pt_rsp_ready), .pt_rsp_ok(pt_rsp_ok),
    .pt_rsp_ppn(pt_rsp_ppn), .flush(flush), .inval_valid(inval_valid),
    .inval_ppn(inval_ppn), .busy(busy)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One lookup, end to end. A miss is served by the page table with the given reply.
  task automatic lookup(input logic [31:0] va, input bit ok, input logic [19:0] ppn,
                        input int pt_dly, input int res_dly, input bit flush_at_rsp,
                        output bit miss, output bit fault, output logic [31:0] pa);
    @(negedge clk);
    chk(req_ready == 1'b1, "R3 ready before lookup", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    if (res_valid) begin
      miss = 1'b0;
    end else begin
      miss = 1'b1;
      chk(pt_req_valid && busy && !req_ready, "R3 request raised", 32'(pt_req_valid), 32'd1);
      chk(pt_req_vpn == va[31:12], "R3 request page", 32'(pt_req_vpn), 32'(va[31:12]));
      for (int k = 0; k < pt_dly; k++) begin
        @(negedge clk);
        chk(pt_req_valid && pt_req_vpn == va[31:12], "R9 request held",
            32'(pt_req_vpn), 32'(va[31:12]));
      end
      pt_req_ready = 1'b1;
      @(negedge clk);
      pt_req_ready = 1'b0;
      pt_rsp_valid = 1'b1;
      pt_rsp_ok    = ok;
      pt_rsp_ppn   = ppn;
      flush        = flush_at_rsp;
      @(negedge clk);
      pt_rsp_valid = 1'b0;
      flush        = 1'b0;
    end
    chk(res_valid == 1'b1, "R2 result valid", 32'(res_valid), 32'd1);
    fault = res_fault;
    pa    = res_paddr;
    for (int k = 0; k < res_dly; k++) begin
      @(negedge clk);
      chk(res_valid && res_paddr == pa && res_fault == fault, "R9 result held", res_paddr, pa);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && req_ready && !busy, "R3 idle after result", 32'(busy), 32'd0);
  endtask

  initial begin
    bit miss, fault;
    logic [31:0] pa;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    chk(!busy && !res_valid && !pt_req_valid, "R1 idle outputs", 32'(busy), 32'd0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [ROW_W-1:0] row;
      row = VEC[i];
      lookup(row[86:55], row[54], row[53:34], i % 3, i % 2, 1'b0, miss, fault, pa);
      chk(miss == row[33], $sformatf("R2/R3 row %0d miss", i), 32'(miss), 32'(row[33]));
      chk(fault == row[32], $sformatf("R5 row %0d fault", i), 32'(fault), 32'(row[32]));
      chk(pa == row[31:0], $sformatf("R4 row %0d paddr", i), pa, row[31:0]);
    end

    // R8: two pages mapped to physical page 8, then invalidate that page
    lookup(32'h00003000, 1'b1, 20'h00008, 0, 0, 1'b0, miss, fault, pa);
    chk(miss && pa == 32'h00008000, "R8 second mapping", pa, 32'h00008000);
    @(negedge clk);
    inval_valid = 1'b1;
    inval_ppn   = 20'h00008;
    @(negedge clk);
    inval_valid = 1'b0;
    lookup(32'hFFFFF010, 1'b0, 20'h0, 0, 0, 1'b0, miss, fault, pa);
    chk(!miss && pa == 32'h00055010, "R8 other page kept", pa, 32'h00055010);
    lookup(32'h00777020, 1'b0, 20'h0, 0, 0, 1'b0, miss, fault, pa);
    chk(!miss && pa == 32'h00101020, "R8 other page kept", pa, 32'h00101020);
    lookup(32'h00002000, 1'b1, 20'h00008, 0, 0, 1'b0, miss, fault, pa);
    chk(miss == 1'b1, "R8 page 2 dropped", 32'(miss), 32'd1);
    lookup(32'h00003000, 1'b1, 20'h00009, 0, 0, 1'b0, miss, fault, pa);
    chk(miss == 1'b1 && pa == 32'h00009000, "R8 page 3 dropped", pa, 32'h00009000);

    // R7: flush empties everything
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    lookup(32'hFFFFF000, 1'b1, 20'h00055, 0, 0, 1'b0, miss, fault, pa);
    chk(miss == 1'b1, "R7 miss after flush", 32'(miss), 32'd1);
    lookup(32'h00002000, 1'b1, 20'h00008, 0, 0, 1'b0, miss, fault, pa);
    chk(miss == 1'b1, "R7 miss after flush", 32'(miss), 32'd1);

    // R7: flush in the install cycle cancels the store but still returns the result
    lookup(32'h00444ABC, 1'b1, 20'h00444, 1, 1, 1'b1, miss, fault, pa);
    chk(miss && !fault && pa == 32'h00444ABC, "R7 result on flushed install", pa, 32'h00444ABC);
    lookup(32'h00444000, 1'b1, 20'h00444, 0, 0, 1'b0, miss, fault, pa);
    chk(miss == 1'b1, "R7 flushed install not stored", 32'(miss), 32'd1);
    lookup(32'hFFFFF000, 1'b1, 20'h00055, 0, 0, 1'b0, miss, fault, pa);
    chk(miss == 1'b1, "R7 earlier page also dropped", 32'(miss), 32'd1);

    // R9: longer back-pressure on both sides, then a hit under back-pressure
    lookup(32'h00ABC123, 1'b1, 20'h0C0DE, 4, 5, 1'b0, miss, fault, pa);
    chk(pa == 32'h0C0DE123, "R9 paddr after stalls", pa, 32'h0C0DE123);
    lookup(32'h00ABC7FF, 1'b0, 20'h0, 0, 4, 1'b0, miss, fault, pa);
    chk(!miss && pa == 32'h0C0DE7FF, "R9 R2 hit after stalls", pa, 32'h0C0DE7FF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule